// File: doc/BRIEF.md
# Checking Store Buffer

This block sits between a core's store path and memory in a redundant-execution scheme. Every program store reaches it twice. The first copy is the leading primary store. The second is a trailing duplicate whose address and data come from a separate shadow register set. A primary copy takes a free slot in a circular buffer. A duplicate is compared with the oldest primary that has not been paired yet. If both the address and the data agree, that slot is marked as checked.

Checked slots drain to a valid/ready memory write port in allocation order, at most one per cycle. Each slot leaves as a single write. The block raises a sticky fault in three cases: a duplicate disagrees with its primary, a duplicate arrives with no primary waiting, or the oldest unpaired primary waits longer than a programmable limit. Once the fault is raised, no store leaves and no new store is accepted until reset.

When every slot is occupied, primary stores are stalled. Duplicates are still accepted, because a duplicate frees the way for a drain.

Top module: `store_check_buf`

## Requirements
- R1: A duplicate is compared with the oldest unpaired primary entry, so pairing follows program order. It is counted as a match only when both address and data are equal.
- R2: Each matched store is written to the memory port exactly once, with the primary's address and data. Writes leave in the order the primaries were accepted, even when primaries and duplicates arrive interleaved.
- R3: A duplicate whose address or data differs from its primary sets `fault_o` and `fault_cause_o` = 1. That store never appears on the memory port.
- R4: A duplicate accepted while no unpaired primary exists sets `fault_o` with `fault_cause_o` = 2.
- R5: With DEPTH entries occupied, `st_ready_o` is low for a primary store (`st_dup_i` = 0) and high for a duplicate (`st_dup_i` = 1).
- R6: While `mem_valid_o` is high and `mem_ready_i` is low, `mem_valid_o`, `mem_addr_o` and `mem_data_o` hold. One write completes per cycle on which both are high.
- R7: Take a primary accepted at clock edge E0 that stays unpaired. `fault_o` is still low after edge E0+L and is high with `fault_cause_o` = 3 after edge E0+L+1, where L is `timeout_lim_i`. A duplicate that arrives earlier prevents the fault.
- R8: `fault_o` is sticky until reset. While it is high, `mem_valid_o` and `st_ready_o` stay low.
- R9: On a cycle in which a primary is accepted and a write drains, occupancy is unchanged.
- R10: After reset the buffer is empty: `mem_valid_o` = 0, `fault_o` = 0, `fault_cause_o` = 0, and `st_ready_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store copy present |
| st_dup_i | input | 1 | 1 = duplicate copy, 0 = primary copy |
| st_addr_i | input | AW | Store address |
| st_data_i | input | DW | Store data |
| st_ready_o | output | 1 | Store copy accepted when high with st_valid_i |
| mem_valid_o | output | 1 | Checked store offered to memory |
| mem_addr_o | output | AW | Write address |
| mem_data_o | output | DW | Write data |
| mem_ready_i | input | 1 | Memory takes the write |
| timeout_lim_i | input | TW | Maximum wait for an unpaired primary, in cycles |
| fault_o | output | 1 | Sticky fault detected |
| fault_cause_o | output | 2 | 0 none, 1 mismatch, 2 orphan duplicate, 3 timeout |

## Verification
The bench builds the buffer with DEPTH = 4 and 8-bit address and data. With these values, every pairing distance from one to the full depth can be swept, and the full-buffer stall is reached after only four primaries. A timer width of 8 lets the timeout be checked at its exact boundary edge with a small limit. The same width still allows the default limit of 64 during the sweeps. Each fault cause is produced separately from a clean reset, and the bench then confirms that no write leaks afterwards.

// File: rtl/store_check_buf_pkg.sv
package store_check_buf_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_MISMATCH = 2'd1,
    CAUSE_ORPHAN   = 2'd2,
    CAUSE_TIMEOUT  = 2'd3
  } fault_cause_e;
endpackage

// File: rtl/scb_ring_ctrl.sv
module scb_ring_ctrl #(
  parameter int DEPTH = 8,
  parameter int PW    = 3,
  parameter int CW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pair_i,
  input  logic          pop_i,
  output logic [PW-1:0] tail_o,
  output logic [PW-1:0] pair_o,
  output logic [PW-1:0] head_o,
  output logic [CW-1:0] occ_o,
  output logic [CW-1:0] unp_o
);
  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tail_o <= '0;
      pair_o <= '0;
      head_o <= '0;
      occ_o  <= '0;
      unp_o  <= '0;
    end else begin
      if (push_i) tail_o <= nxt(tail_o);
      if (pair_i) pair_o <= nxt(pair_o);
      if (pop_i)  head_o <= nxt(head_o);
      case ({push_i, pop_i})
        2'b10:   occ_o <= occ_o + 1'b1;
        2'b01:   occ_o <= occ_o - 1'b1;
        default: occ_o <= occ_o;
      endcase
      case ({push_i, pair_i})
        2'b10:   unp_o <= unp_o + 1'b1;
        2'b01:   unp_o <= unp_o - 1'b1;
        default: unp_o <= unp_o;
      endcase
    end
  end
endmodule

// File: rtl/scb_cmp.sv
module scb_cmp #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int LANES = 4
) (
  input  logic [AW-1:0] a_ref_i,
  input  logic [DW-1:0] d_ref_i,
  input  logic [AW-1:0] a_dup_i,
  input  logic [DW-1:0] d_dup_i,
  output logic          match_o
);
  localparam int TOT  = AW + DW;
  localparam int LW   = (TOT + LANES - 1) / LANES;
  localparam int PADW = LW * LANES;

  logic [PADW-1:0]  ref_w, dup_w;
  logic [LANES-1:0] lane_eq;

  assign ref_w = PADW'({a_ref_i, d_ref_i});
  assign dup_w = PADW'({a_dup_i, d_dup_i});

  // lane-split compare keeps the reduction tree shallow per lane
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_eq[l] = (ref_w[l*LW +: LW] == dup_w[l*LW +: LW]);
  end

  assign match_o = &lane_eq;
endmodule

// File: rtl/scb_wait_timer.sv
module scb_wait_timer #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          waiting_i,
  input  logic          progress_i,
  input  logic [TW-1:0] lim_i,
  output logic          expired_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (!waiting_i || progress_i) cnt_q <= '0;
    else if (cnt_q != '1)            cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = waiting_i && !progress_i && (cnt_q >= lim_i);
endmodule

// File: rtl/store_check_buf.sv
module store_check_buf
  import store_check_buf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int TW    = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          st_valid_i,
  input  logic          st_dup_i,
  input  logic [AW-1:0] st_addr_i,
  input  logic [DW-1:0] st_data_i,
  output logic          st_ready_o,
  output logic          mem_valid_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_data_o,
  input  logic          mem_ready_i,
  input  logic [TW-1:0] timeout_lim_i,
  output logic          fault_o,
  output logic [1:0]    fault_cause_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [DEPTH-1:0] used_q, checked_q;
  logic [PW-1:0]    tail, pair_ptr, head;
  logic [CW-1:0]    occ, unp;
  logic             fault_q;
  fault_cause_e     cause_q;

  logic full, have_unp, match, expired;
  logic acc_pri, acc_dup, do_pair, dup_bad, do_pop;

  assign full       = (occ == CW'(DEPTH));
  assign have_unp   = (unp != '0);
  assign st_ready_o = !fault_q && (st_dup_i || !full);
  assign acc_pri    = st_valid_i && !st_dup_i && st_ready_o;
  assign acc_dup    = st_valid_i && st_dup_i && st_ready_o;
  assign do_pair    = acc_dup && have_unp && match;
  assign dup_bad    = acc_dup && !(have_unp && match);

  assign mem_valid_o = !fault_q && used_q[head] && checked_q[head];
  assign mem_addr_o  = addr_q[head];
  assign mem_data_o  = data_q[head];
  assign do_pop      = mem_valid_o && mem_ready_i;

  scb_ring_ctrl #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) u_ring (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (acc_pri),
    .pair_i (do_pair),
    .pop_i  (do_pop),
    .tail_o (tail),
    .pair_o (pair_ptr),
    .head_o (head),
    .occ_o  (occ),
    .unp_o  (unp)
  );

  scb_cmp #(.AW(AW), .DW(DW), .LANES(4)) u_cmp (
    .a_ref_i (addr_q[pair_ptr]),
    .d_ref_i (data_q[pair_ptr]),
    .a_dup_i (st_addr_i),
    .d_dup_i (st_data_i),
    .match_o (match)
  );

  scb_wait_timer #(.TW(TW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .waiting_i  (have_unp && !fault_q),
    .progress_i (do_pair),
    .lim_i      (timeout_lim_i),
    .expired_o  (expired)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        used_q[i]    <= 1'b0;
        checked_q[i] <= 1'b0;
      end else begin
        if (acc_pri && tail == PW'(i)) begin
          used_q[i]    <= 1'b1;
          checked_q[i] <= 1'b0;
        end else if (do_pop && head == PW'(i)) begin
          used_q[i]    <= 1'b0;
          checked_q[i] <= 1'b0;
        end
        if (do_pair && pair_ptr == PW'(i)) checked_q[i] <= 1'b1;
      end
    end

    always_ff @(posedge clk_i) begin
      if (acc_pri && tail == PW'(i)) begin
        addr_q[i] <= st_addr_i;
        data_q[i] <= st_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else if (!fault_q) begin
      if (dup_bad) begin
        fault_q <= 1'b1;
        cause_q <= have_unp ? CAUSE_MISMATCH : CAUSE_ORPHAN;
      end else if (expired) begin
        fault_q <= 1'b1;
        cause_q <= CAUSE_TIMEOUT;
      end
    end
  end

  assign fault_o       = fault_q;
  assign fault_cause_o = cause_q;
endmodule

// File: rtl/scb_checker.sv
module scb_checker #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CW    = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          st_valid_i,
  input logic          st_dup_i,
  input logic          st_ready_o,
  input logic          mem_valid_o,
  input logic          mem_ready_i,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_data_o,
  input logic          fault_o,
  input logic [CW-1:0] occ,
  input logic [CW-1:0] unp
);
  assert_unpaired_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unp <= occ);

  assert_drain_needs_check_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> (occ > unp));

  assert_full_blocks_primary_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ == CW'(DEPTH) && st_valid_i && !st_dup_i) |-> !st_ready_o);

  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ <= CW'(DEPTH));

  assert_hold_under_stall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=>
      (fault_o || (mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o))));

  assert_quiet_on_fault_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!mem_valid_o && !st_ready_o));

  assert_fault_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> fault_o);

  assert_push_pop_count_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_i && !st_dup_i && st_ready_o && mem_valid_o && mem_ready_i) |=>
      (occ == $past(occ)));
endmodule

bind store_check_buf scb_checker #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .st_valid_i  (st_valid_i),
  .st_dup_i    (st_dup_i),
  .st_ready_o  (st_ready_o),
  .mem_valid_o (mem_valid_o),
  .mem_ready_i (mem_ready_i),
  .mem_addr_o  (mem_addr_o),
  .mem_data_o  (mem_data_o),
  .fault_o     (fault_o),
  .occ         (occ),
  .unp         (unp)
);

// File: tb/tb_store_check_buf.sv
module tb_store_check_buf;
  localparam int DEPTH = 4;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st_valid = 1'b0, st_dup = 1'b0;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic st_ready, mem_valid, mem_ready = 1'b1;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;
  logic [TW-1:0] lim = 8'd64;
  logic fault;
  logic [1:0] cause;

  int n_chk = 0, n_fail = 0, wr_n = 0;
  logic [AW-1:0] wr_a [64];
  logic [DW-1:0] wr_d [64];

  always #4 clk = ~clk;

  store_check_buf #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .TW(TW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .st_valid_i(st_valid), .st_dup_i(st_dup), .st_addr_i(st_addr), .st_data_i(st_data),
    .st_ready_o(st_ready),
    .mem_valid_o(mem_valid), .mem_addr_o(mem_addr), .mem_data_o(mem_data),
    .mem_ready_i(mem_ready), .timeout_lim_i(lim),
    .fault_o(fault), .fault_cause_o(cause)
  );

  // records handshakes 1 ns before the edge that completes them
  always begin
    @(negedge clk);
    #3;
    if (rst_n && mem_valid && mem_ready && wr_n < 64) begin
      wr_a[wr_n] = mem_addr;
      wr_d[wr_n] = mem_data;
      wr_n++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; st_valid = 1'b0; st_dup = 1'b0; mem_ready = 1'b1; lim = 8'd64;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send(input logic dup, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    st_valid = 1'b1; st_dup = dup; st_addr = a; st_data = d;
    @(negedge clk);
    st_valid = 1'b0; st_dup = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
    #3;
  endtask

  function automatic logic [7:0] dat(input logic [7:0] a);
    return a ^ 8'h5A;
  endfunction

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int base;
    do_reset();
    #3;
    // R10 reset state
    check("R10 ready", int'(st_ready), 1);
    check("R10 mem_valid", int'(mem_valid), 0);
    check("R10 fault", int'(fault), 0);
    check("R10 cause", int'(cause), 0);

    // R1 R2 sweep of pairing distance 1..DEPTH
    for (int k = 1; k <= DEPTH; k++) begin
      base = wr_n;
      for (int i = 0; i < k; i++) send(1'b0, 8'(k*16+i), dat(8'(k*16+i)));
      for (int i = 0; i < k; i++) send(1'b1, 8'(k*16+i), dat(8'(k*16+i)));
      settle(6);
      check("R2 write count", wr_n - base, k);
      for (int i = 0; i < k; i++) begin
        check("R2 order addr", int'(wr_a[base+i]), k*16+i);
        check("R1 data", int'(wr_d[base+i]), int'(dat(8'(k*16+i))));
      end
      check("R1 no fault", int'(fault), 0);
    end

    // R2 interleaved P0 D0 P1 P2 D1 D2
    base = wr_n;
    send(1'b0, 8'hA0, 8'h01); send(1'b1, 8'hA0, 8'h01);
    send(1'b0, 8'hA1, 8'h02); send(1'b0, 8'hA2, 8'h03);
    send(1'b1, 8'hA1, 8'h02); send(1'b1, 8'hA2, 8'h03);
    settle(4);
    check("R2 interleave count", wr_n - base, 3);
    for (int i = 0; i < 3; i++) begin
      check("R2 interleave addr", int'(wr_a[base+i]), 'hA0 + i);
      check("R2 interleave data", int'(wr_d[base+i]), 1 + i);
    end

    // R6 backpressure hold
    mem_ready = 1'b0;
    base = wr_n;
    send(1'b0, 8'h33, 8'h44); send(1'b1, 8'h33, 8'h44);
    for (int c = 0; c < 3; c++) begin
      settle(1);
      check("R6 valid held", int'(mem_valid), 1);
      check("R6 addr held", int'(mem_addr), 'h33);
      check("R6 data held", int'(mem_data), 'h44);
    end
    @(negedge clk); mem_ready = 1'b1;
    settle(1);
    check("R6 single write", wr_n - base, 1);
    check("R6 drained", int'(mem_valid), 0);

    // R5 full stalls primary, duplicate still accepted
    mem_ready = 1'b0;
    base = wr_n;
    for (int i = 0; i < DEPTH; i++) send(1'b0, 8'(8'hC0+i), 8'(i));
    @(negedge clk);
    st_valid = 1'b1; st_dup = 1'b0; st_addr = 8'hEE; st_data = 8'hEE;
    #1;
    check("R5 primary stalled", int'(st_ready), 0);
    st_dup = 1'b1;
    #1;
    check("R5 duplicate accepted", int'(st_ready), 1);
    st_valid = 1'b0; st_dup = 1'b0;
    for (int i = 0; i < DEPTH; i++) send(1'b1, 8'(8'hC0+i), 8'(i));
    mem_ready = 1'b1;
    settle(DEPTH + 2);
    check("R5 drained all", wr_n - base, DEPTH);
    check("R5 last addr", int'(wr_a[base+DEPTH-1]), 'hC0 + DEPTH - 1);

    // R9 simultaneous push and drain keeps occupancy
    do_reset();
    mem_ready = 1'b0;
    for (int i = 0; i < DEPTH-1; i++) begin
      send(1'b0, 8'(8'h60+i), 8'(i)); send(1'b1, 8'(8'h60+i), 8'(i));
    end
    @(negedge clk);
    mem_ready = 1'b1; st_valid = 1'b1; st_dup = 1'b0; st_addr = 8'h70; st_data = 8'h70;
    #1;
    check("R9 push with drain", int'(st_ready && mem_valid), 1);
    @(negedge clk);
    mem_ready = 1'b0; st_addr = 8'h71; st_data = 8'h71;
    #1;
    check("R9 room after swap", int'(st_ready), 1);
    @(negedge clk);
    st_addr = 8'h72;
    #1;
    check("R9 full after one more", int'(st_ready), 0);
    st_valid = 1'b0;

    // R3 data mismatch
    do_reset();
    base = wr_n;
    send(1'b0, 8'h40, 8'h11); send(1'b1, 8'h40, 8'h12);
    settle(2);
    check("R3 data mismatch fault", int'(fault), 1);
    check("R3 cause", int'(cause), 1);
    check("R8 ready low", int'(st_ready), 0);
    send(1'b0, 8'h41, 8'h11); send(1'b1, 8'h41, 8'h11);
    settle(3);
    check("R3 no write", wr_n - base, 0);
    check("R8 sticky", int'(fault), 1);
    check("R8 no valid", int'(mem_valid), 0);

    // R3 address mismatch
    do_reset();
    base = wr_n;
    send(1'b0, 8'h40, 8'h11); send(1'b1, 8'h41, 8'h11);
    settle(3);
    check("R3 addr mismatch fault", int'(fault), 1);
    check("R3 addr cause", int'(cause), 1);
    check("R3 addr no write", wr_n - base, 0);

    // R4 orphan duplicate
    do_reset();
    send(1'b1, 8'h50, 8'h50);
    settle(1);
    check("R4 orphan fault", int'(fault), 1);
    check("R4 cause", int'(cause), 2);

    // R7 exact timeout boundary
    do_reset();
    lim = 8'd10;
    send(1'b0, 8'h90, 8'h90);
    repeat (10) @(negedge clk);
    #3;
    check("R7 no fault at limit", int'(fault), 0);
    settle(1);
    check("R7 fault past limit", int'(fault), 1);
    check("R7 cause", int'(cause), 3);

    // R7 duplicate in time avoids fault
    do_reset();
    lim = 8'd10;
    base = wr_n;
    send(1'b0, 8'h91, 8'h19);
    repeat (7) @(negedge clk);
    send(1'b1, 8'h91, 8'h19);
    settle(20);
    check("R7 in-time no fault", int'(fault), 0);
    check("R7 in-time write", wr_n - base, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule